// File: doc/BRIEF.md
# Two-Operand ALU with Status Byte

This block is the arithmetic and logic stage of a small 16-bit RISC core. Each issued operation reads the destination register value as its first operand. The second operand comes either from a source register value or from a 16-bit immediate. The block then produces a registered result, a write-back strobe, and an updated 8-bit status byte.

The available operations are add, subtract, AND, OR, NOR, logical shift left and logical shift right. There is also a compare that changes only the flags. The status byte carries carry, overflow, negative, zero, a signed less-than flag and an interrupt-enable bit. The interrupt-enable bit is changed only by two dedicated inputs.

Register storage, multiply, divide and instruction decoding sit outside the block. A decoder in the core drives the operation select directly. Results and flags appear on the outputs one clock edge after the operation is presented with `opValid` high.

Top module: `alu_status_unit`

## Requirements
- R1: Operation select encoding is 0 add, 1 subtract, 2 AND, 3 OR, 4 NOR, 5 shift left, 6 shift right, 7 compare. On the clock edge that samples `opValid` high with an operation from 0 to 6, `result` takes the operation's value and `resultWe` is 1 for that one cycle.
- R2: Add gives rd + op2 modulo 2^16. Carry (bit 0) is the carry out, and overflow (bit 1) flags a signed overflow.
- R3: Subtract gives rd - op2 modulo 2^16. Carry means no borrow (rd >= op2 unsigned), and overflow flags a signed overflow.
- R4: AND, OR and NOR (the inverse of OR) of rd and op2 clear both carry and overflow.
- R5: Shifts are logical and take their count from `immVal`, whatever `useImm` is. Carry receives the last bit shifted out, and overflow is cleared. A count of 16 or more gives 0. A count of 0 or above 16 gives carry 0.
- R6: Compare updates carry, overflow, negative, zero and less-than as a subtract would. `resultWe` stays 0 and `result` keeps its previous value.
- R7: For every operation from 0 to 7, negative (bit 2) is the result's top bit and zero (bit 3) is set exactly when the result is 0.
- R8: Less-than (bit 5) is set by subtract and compare to signed rd < op2. All other operations leave it unchanged.
- R9: The status byte is laid out as c bit 0, o bit 1, n bit 2, z bit 3, interrupt-enable bit 4, less-than bit 5. Bits 7:6 always read 0.
- R10: `useImm` = 1 selects `immVal` as op2. `useImm` = 0 selects `rsVal`.
- R11: `intEnSet` sets bit 4 and `intEnClr` clears it on the next edge. Clear wins when both are high. ALU operations never change bit 4.
- R12: With `opValid` low, or with an operation select of 8 to 15, nothing is written and the whole status byte is unchanged, apart from an interrupt-enable request.
- R13: While `rstN` is low, `result`, `resultWe` and `status` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| opValid | input | 1 | Operation presented this cycle |
| opSel | input | 4 | Operation select |
| useImm | input | 1 | Second operand from immediate |
| rdVal | input | 16 | Destination/first operand value |
| rsVal | input | 16 | Source register value |
| immVal | input | 16 | Immediate value and shift count |
| intEnSet | input | 1 | Set interrupt-enable |
| intEnClr | input | 1 | Clear interrupt-enable |
| result | output | 16 | Registered result |
| resultWe | output | 1 | Write-back strobe for rd |
| status | output | 8 | Status byte |

## Verification
The assertions assume that the clock-domain inputs are stable around the rising edge. They also assume that `opSel` carries a known value whenever `opValid` is high. The zero and interrupt-enable properties also assume that reset is applied once before any operation.

The stimulus drives every input on the falling edge only and keeps all inputs at defined values, including idle cycles. Undefined selects 8 to 15 are exercised only on purpose. Set and clear requests, both alone and together, are mixed with ALU operations so that the interrupt-enable hold rule is checked while the other flags are moving.

// File: rtl/alu_pkg.sv
package alu_pkg;

  localparam int OP_W   = 4;
  localparam int STAT_W = 8;

  // status byte bit positions
  localparam int ST_C = 0;
  localparam int ST_O = 1;
  localparam int ST_N = 2;
  localparam int ST_Z = 3;
  localparam int ST_I = 4;
  localparam int ST_L = 5;

  typedef enum logic [OP_W-1:0] {
    OP_ADD = 4'd0,
    OP_SUB = 4'd1,
    OP_AND = 4'd2,
    OP_OR  = 4'd3,
    OP_NOR = 4'd4,
    OP_SHL = 4'd5,
    OP_SHR = 4'd6,
    OP_CMP = 4'd7
  } aluOp_e;

  typedef enum logic [1:0] {
    LG_AND = 2'd0,
    LG_OR  = 2'd1,
    LG_NOR = 2'd2
  } logicKind_e;

  // strobes steering the datapath
  typedef struct packed {
    logic       selSum;
    logic       subMode;
    logic       selLogic;
    logic [1:0] logicKind;
    logic       selShift;
    logic       shiftLeft;
  } dpCtrl_t;

  // strobes steering the result/status registers
  typedef struct packed {
    logic writeBack;
    logic flagUpd;
    logic lessUpd;
  } regCtrl_t;

endpackage

// File: rtl/alu_ctrl.sv
module alu_ctrl
  import alu_pkg::*;
(
  input  logic            opValid,
  input  logic [OP_W-1:0] opSel,
  output dpCtrl_t         dpCtrl,
  output regCtrl_t        regCtrl
);

  regCtrl_t rawReg;

  always_comb begin
    dpCtrl = '0;
    rawReg = '0;
    case (opSel)
      OP_ADD: begin
        dpCtrl.selSum    = 1'b1;
        rawReg.writeBack = 1'b1;
        rawReg.flagUpd   = 1'b1;
      end
      OP_SUB: begin
        dpCtrl.selSum    = 1'b1;
        dpCtrl.subMode   = 1'b1;
        rawReg.writeBack = 1'b1;
        rawReg.flagUpd   = 1'b1;
        rawReg.lessUpd   = 1'b1;
      end
      OP_CMP: begin
        dpCtrl.selSum    = 1'b1;
        dpCtrl.subMode   = 1'b1;
        rawReg.flagUpd   = 1'b1;
        rawReg.lessUpd   = 1'b1;
      end
      OP_AND: begin
        dpCtrl.selLogic  = 1'b1;
        dpCtrl.logicKind = LG_AND;
        rawReg.writeBack = 1'b1;
        rawReg.flagUpd   = 1'b1;
      end
      OP_OR: begin
        dpCtrl.selLogic  = 1'b1;
        dpCtrl.logicKind = LG_OR;
        rawReg.writeBack = 1'b1;
        rawReg.flagUpd   = 1'b1;
      end
      OP_NOR: begin
        dpCtrl.selLogic  = 1'b1;
        dpCtrl.logicKind = LG_NOR;
        rawReg.writeBack = 1'b1;
        rawReg.flagUpd   = 1'b1;
      end
      OP_SHL: begin
        dpCtrl.selShift  = 1'b1;
        dpCtrl.shiftLeft = 1'b1;
        rawReg.writeBack = 1'b1;
        rawReg.flagUpd   = 1'b1;
      end
      OP_SHR: begin
        dpCtrl.selShift  = 1'b1;
        rawReg.writeBack = 1'b1;
        rawReg.flagUpd   = 1'b1;
      end
      default: begin
        dpCtrl = '0;
        rawReg = '0;
      end
    endcase
  end

  // register strobes only fire on a presented operation
  always_comb begin
    regCtrl.writeBack = rawReg.writeBack & opValid;
    regCtrl.flagUpd   = rawReg.flagUpd   & opValid;
    regCtrl.lessUpd   = rawReg.lessUpd   & opValid;
  end

endmodule

// File: rtl/alu_datapath.sv
module alu_datapath
  import alu_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  dpCtrl_t           dpCtrl,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic [DATA_W-1:0] shCount,
  output logic [DATA_W-1:0] aluRes,
  output logic              carryOut,
  output logic              ovfOut,
  output logic              lessOut
);

  localparam int CNT_W = $clog2(DATA_W + 2);
  localparam int MSB   = DATA_W - 1;

  // adder / subtractor
  logic [DATA_W-1:0] addendB;
  logic [DATA_W:0]   sumWide;
  logic              sumOvf;

  always_comb begin
    addendB = dpCtrl.subMode ? ~opB : opB;
    sumWide = {1'b0, opA} + {1'b0, addendB} + (DATA_W+1)'(dpCtrl.subMode);
    sumOvf  = (opA[MSB] == addendB[MSB]) && (sumWide[MSB] != opA[MSB]);
  end

  // logic unit
  logic [DATA_W-1:0] logicRes;

  always_comb begin
    case (dpCtrl.logicKind)
      LG_AND:  logicRes = opA & opB;
      LG_OR:   logicRes = opA | opB;
      LG_NOR:  logicRes = ~(opA | opB);
      default: logicRes = '0;
    endcase
  end

  // shifter, count clamped so every count above DATA_W behaves alike
  logic [CNT_W-1:0] shAmt;
  logic [DATA_W:0]  leftWide;
  logic [DATA_W:0]  rightWide;

  always_comb begin
    if (int'(shCount) > DATA_W) shAmt = CNT_W'(DATA_W + 1);
    else                        shAmt = CNT_W'(shCount);
    leftWide  = {1'b0, opA} << shAmt;
    rightWide = {opA, 1'b0} >> shAmt;
  end

  // output select
  always_comb begin
    aluRes   = '0;
    carryOut = 1'b0;
    ovfOut   = 1'b0;
    if (dpCtrl.selSum) begin
      aluRes   = sumWide[MSB:0];
      carryOut = sumWide[DATA_W];
      ovfOut   = sumOvf;
    end else if (dpCtrl.selLogic) begin
      aluRes = logicRes;
    end else if (dpCtrl.selShift) begin
      if (dpCtrl.shiftLeft) begin
        aluRes   = leftWide[MSB:0];
        carryOut = leftWide[DATA_W];
      end else begin
        aluRes   = rightWide[DATA_W:1];
        carryOut = rightWide[0];
      end
    end
    lessOut = sumWide[MSB] ^ sumOvf;
  end

endmodule

// File: rtl/alu_flagreg.sv
module alu_flagreg
  import alu_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  regCtrl_t          regCtrl,
  input  logic [DATA_W-1:0] aluRes,
  input  logic              carryIn,
  input  logic              ovfIn,
  input  logic              lessIn,
  input  logic              intEnSet,
  input  logic              intEnClr,
  output logic [DATA_W-1:0] result,
  output logic              resultWe,
  output logic [STAT_W-1:0] status
);

  logic flagC, flagO, flagN, flagZ, flagI, flagL;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      result   <= '0;
      resultWe <= 1'b0;
    end else begin
      resultWe <= regCtrl.writeBack;
      if (regCtrl.writeBack) result <= aluRes;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flagC <= 1'b0;
      flagO <= 1'b0;
      flagN <= 1'b0;
      flagZ <= 1'b0;
      flagL <= 1'b0;
    end else begin
      if (regCtrl.flagUpd) begin
        flagC <= carryIn;
        flagO <= ovfIn;
        flagN <= aluRes[DATA_W-1];
        flagZ <= (aluRes == '0);
      end
      if (regCtrl.lessUpd) flagL <= lessIn;
    end
  end

  // interrupt enable: clear has priority
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         flagI <= 1'b0;
    else if (intEnClr) flagI <= 1'b0;
    else if (intEnSet) flagI <= 1'b1;
  end

  always_comb begin
    status       = '0;
    status[ST_C] = flagC;
    status[ST_O] = flagO;
    status[ST_N] = flagN;
    status[ST_Z] = flagZ;
    status[ST_I] = flagI;
    status[ST_L] = flagL;
  end

endmodule

// File: rtl/alu_status_unit.sv
module alu_status_unit
  import alu_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              opValid,
  input  logic [OP_W-1:0]   opSel,
  input  logic              useImm,
  input  logic [DATA_W-1:0] rdVal,
  input  logic [DATA_W-1:0] rsVal,
  input  logic [DATA_W-1:0] immVal,
  input  logic              intEnSet,
  input  logic              intEnClr,
  output logic [DATA_W-1:0] result,
  output logic              resultWe,
  output logic [STAT_W-1:0] status
);

  dpCtrl_t           dpCtrl;
  regCtrl_t          regCtrl;
  logic [DATA_W-1:0] opSecond;
  logic [DATA_W-1:0] aluRes;
  logic              carryW, ovfW, lessW;

  assign opSecond = useImm ? immVal : rsVal;

  alu_ctrl u_ctrl (
    .opValid (opValid),
    .opSel   (opSel),
    .dpCtrl  (dpCtrl),
    .regCtrl (regCtrl)
  );

  alu_datapath #(.DATA_W(DATA_W)) u_dp (
    .dpCtrl   (dpCtrl),
    .opA      (rdVal),
    .opB      (opSecond),
    .shCount  (immVal),
    .aluRes   (aluRes),
    .carryOut (carryW),
    .ovfOut   (ovfW),
    .lessOut  (lessW)
  );

  alu_flagreg #(.DATA_W(DATA_W)) u_reg (
    .clk      (clk),
    .rstN     (rstN),
    .regCtrl  (regCtrl),
    .aluRes   (aluRes),
    .carryIn  (carryW),
    .ovfIn    (ovfW),
    .lessIn   (lessW),
    .intEnSet (intEnSet),
    .intEnClr (intEnClr),
    .result   (result),
    .resultWe (resultWe),
    .status   (status)
  );

endmodule

// File: rtl/alu_status_chk.sv
module alu_status_chk
  import alu_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              opValid,
  input logic [OP_W-1:0]   opSel,
  input logic              intEnSet,
  input logic              intEnClr,
  input logic [DATA_W-1:0] result,
  input logic              resultWe,
  input logic [STAT_W-1:0] status
);

  assert_unused_zero_R9: assert property (@(posedge clk) disable iff (!rstN)
    status[STAT_W-1:ST_L+1] == '0);

  assert_cmp_no_write_R6: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opSel == OP_CMP) |=> !resultWe);

  assert_zero_flag_R7: assert property (@(posedge clk) disable iff (!rstN)
    resultWe |-> (status[ST_Z] == (result == '0)));

  assert_neg_flag_R7: assert property (@(posedge clk) disable iff (!rstN)
    resultWe |-> (status[ST_N] == result[DATA_W-1]));

  assert_idle_hold_R12: assert property (@(posedge clk) disable iff (!rstN)
    (!opValid || opSel > OP_CMP) |=> (!resultWe && $stable(status[ST_L:ST_C] & 6'b101111)));

  assert_ie_clear_R11: assert property (@(posedge clk) disable iff (!rstN)
    intEnClr |=> !status[ST_I]);

  assert_ie_set_R11: assert property (@(posedge clk) disable iff (!rstN)
    (intEnSet && !intEnClr) |=> status[ST_I]);

  assert_ie_hold_R11: assert property (@(posedge clk) disable iff (!rstN)
    (!intEnSet && !intEnClr) |=> $stable(status[ST_I]));

endmodule

bind alu_status_unit alu_status_chk #(.DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .opValid  (opValid),
  .opSel    (opSel),
  .intEnSet (intEnSet),
  .intEnClr (intEnClr),
  .result   (result),
  .resultWe (resultWe),
  .status   (status)
);

// File: tb/sim_alu_status_unit.sv
module sim_alu_status_unit;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        opValid = 1'b0;
  logic [3:0]  opSel = '0;
  logic        useImm = 1'b0;
  logic [15:0] rdVal = '0, rsVal = '0, immVal = '0;
  logic        intEnSet = 1'b0, intEnClr = 1'b0;
  logic [15:0] result;
  logic        resultWe;
  logic [7:0]  status;

  int checks = 0;
  int errors = 0;

  typedef struct {
    logic [15:0] res;
    logic        we;
    logic [7:0]  st;
    string       tag;
  } expItem_t;

  expItem_t    expQ[$];
  logic [15:0] mRes = '0;
  logic [7:0]  mSt  = '0;
  bit          done = 1'b0;

  always #10 clk = ~clk;

  alu_status_unit u0 (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opSel(opSel), .useImm(useImm),
    .rdVal(rdVal), .rsVal(rsVal), .immVal(immVal), .intEnSet(intEnSet),
    .intEnClr(intEnClr), .result(result), .resultWe(resultWe), .status(status)
  );

  task automatic check(string tag, logic [15:0] aRes, logic aWe, logic [7:0] aSt,
                       logic [15:0] eRes, logic eWe, logic [7:0] eSt);
    checks++;
    if (aRes !== eRes || aWe !== eWe || aSt !== eSt) begin
      errors++;
      $display("FAIL %s: actual res=%h we=%b st=%b expected res=%h we=%b st=%b",
               tag, aRes, aWe, aSt, eRes, eWe, eSt);
    end
  endtask

  // reference model written from the requirements
  task automatic issue(string tag, bit v, logic [3:0] op, bit imm,
                       logic [15:0] a, logic [15:0] b, logic [15:0] k,
                       bit iset = 0, bit iclr = 0);
    logic [15:0] op2, r;
    logic c, o, we;
    int sa, sb, d, n;
    expItem_t it;
    @(negedge clk);
    opValid = v; opSel = op; useImm = imm; rdVal = a; rsVal = b; immVal = k;
    intEnSet = iset; intEnClr = iclr;
    op2 = imm ? k : b;
    we = 1'b0;
    if (v && op <= 4'd7) begin
      r = '0; c = 0; o = 0;
      sa = int'($signed(a)); sb = int'($signed(op2));
      case (op)
        4'd0: begin
          {c, r} = {1'b0, a} + {1'b0, op2};
          d = sa + sb; o = (d > 32767) || (d < -32768);
        end
        4'd1, 4'd7: begin
          r = a - op2; c = (a >= op2);
          d = sa - sb; o = (d > 32767) || (d < -32768);
          mSt[5] = (sa < sb);
        end
        4'd2: r = a & op2;
        4'd3: r = a | op2;
        4'd4: r = ~(a | op2);
        4'd5, 4'd6: begin
          r = a;
          n = (int'(k) > 17) ? 17 : int'(k);
          for (int i = 0; i < n; i++) begin
            if (op == 4'd5) begin c = r[15]; r = r << 1; end
            else            begin c = r[0];  r = r >> 1; end
          end
        end
        default: ;
      endcase
      mSt[0] = c; mSt[1] = o; mSt[2] = r[15]; mSt[3] = (r == 16'h0);
      if (op != 4'd7) begin we = 1'b1; mRes = r; end
    end
    if (iclr)      mSt[4] = 1'b0;
    else if (iset) mSt[4] = 1'b1;
    it.res = mRes; it.we = we; it.st = mSt; it.tag = tag;
    expQ.push_back(it);
    @(posedge clk);
  endtask

  // monitor: compare after each edge that produced a result
  always @(posedge clk) begin
    #2;
    if (expQ.size() > 0) begin
      expItem_t e;
      e = expQ.pop_front();
      check(e.tag, result, resultWe, status, e.res, e.we, e.st);
    end
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R13 reset", result, resultWe, status, 16'h0, 1'b0, 8'h0);
    rstN = 1'b1;
    // R1 R2 add with carry out to zero
    issue("R2 add carry", 1, 4'd0, 0, 16'hFFFF, 16'h0001, 16'h0);
    // R2 signed overflow, R10 immediate operand
    issue("R2 R10 add ovf imm", 1, 4'd0, 1, 16'h7FFF, 16'h1234, 16'h0001);
    issue("R10 add rs", 1, 4'd0, 0, 16'h0100, 16'h0023, 16'h5555);
    issue("R3 sub no borrow", 1, 4'd1, 0, 16'h0005, 16'h0003, 16'h0);
    issue("R3 R8 sub borrow", 1, 4'd1, 1, 16'h0003, 16'h0, 16'h0005);
    issue("R3 sub ovf", 1, 4'd1, 0, 16'h8000, 16'h0001, 16'h0);
    issue("R6 R8 cmp neg vs pos", 1, 4'd7, 0, 16'hFFFF, 16'h0001, 16'h0);
    issue("R6 R8 cmp equal", 1, 4'd7, 1, 16'h4242, 16'h0, 16'h4242);
    issue("R4 and", 1, 4'd2, 1, 16'hF0F0, 16'h0, 16'h3C3C);
    issue("R8 and keeps less", 1, 4'd2, 0, 16'h0F0F, 16'hF0F0, 16'h0);
    issue("R4 or", 1, 4'd3, 0, 16'h8001, 16'h0100, 16'h0);
    issue("R4 R7 nor", 1, 4'd4, 1, 16'h00FF, 16'h0, 16'hFF00);
    issue("R5 shl 1", 1, 4'd5, 0, 16'h8001, 16'h0, 16'h0001);
    issue("R5 shr 4", 1, 4'd6, 1, 16'h00F8, 16'h0, 16'h0004);
    issue("R5 shl 0", 1, 4'd5, 0, 16'h1234, 16'h0, 16'h0000);
    issue("R5 shl 16", 1, 4'd5, 0, 16'h0001, 16'h0, 16'd16);
    issue("R5 shr 16", 1, 4'd6, 0, 16'h8000, 16'h0, 16'd16);
    issue("R5 shr 40", 1, 4'd6, 0, 16'hFFFF, 16'h0, 16'd40);
    issue("R5 shr 15", 1, 4'd6, 1, 16'h8000, 16'h0003, 16'd15);
    issue("R3 R8 sub sets less", 1, 4'd1, 0, 16'h8000, 16'h0001, 16'h0);
    issue("R11 ie set", 0, 4'd0, 0, 16'h0, 16'h0, 16'h0, 1, 0);
    issue("R11 ie kept by add", 1, 4'd0, 0, 16'h0001, 16'h0001, 16'h0);
    issue("R11 both clear wins", 0, 4'd0, 0, 16'h0, 16'h0, 16'h0, 1, 1);
    issue("R11 ie set again", 1, 4'd4, 0, 16'hFFFF, 16'h0, 16'h0, 1, 0);
    issue("R12 idle", 0, 4'd0, 0, 16'h7FFF, 16'h7FFF, 16'h0);
    issue("R12 undefined op", 1, 4'd9, 0, 16'hFFFF, 16'h0001, 16'h0);
    issue("R12 undefined op 15", 1, 4'd15, 1, 16'h0, 16'h0, 16'h0);
    issue("R11 ie clear", 0, 4'd0, 0, 16'h0, 16'h0, 16'h0, 0, 1);
    issue("R9 R1 final add", 1, 4'd0, 0, 16'h4000, 16'h4000, 16'h0);
    @(negedge clk);
    opValid = 1'b0;
    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule